// File: doc/BRIEF.md
# Masked Shadow Configuration Update Controller

This block keeps two copies of a small configuration register file. A processor bus writes the master copy at any time, while the slave copy feeds the datapath and changes only at controlled moments. This lets software stage a full new configuration and apply it atomically, or apply only part of it, at a chosen instant.

An update event copies every master into its slave when that register's bit in the update mask is set. There are three possible sources of an event. The first is a rising edge of the software transmit-enable bit. The second is a rising edge of the external transmit-enable pin. The third is a rising edge of the external update pin. The two pins are asynchronous, so each passes through a two-flop synchroniser, and both are honoured only while the pin-enable input is high. When immediate mode is on, a processor write also travels down a four-stage pipeline and then loads the addressed slave directly from its master, whatever the mask says.

Top module: `shadow_cfg_ctrl`

## Requirements
- R1: While reset is asserted, every slave register is zero and `upd_done` is low. The update mask resets to all ones. Register i appears on `slave_q[i*DW +: DW]`.
- R2: When immediate mode is off, a processor write changes only the master copy. The slave output stays as it was.
- R3: On an update event, the slaves whose mask bit (bit i for register i) is set take their master values at the same clock edge that sees the event. Slaves whose mask bit is clear keep their values.
- R4: `upd_done` goes high for exactly one cycle, starting right after the edge that performs a masked transfer.
- R5: In immediate mode, a write sampled at edge N loads the addressed slave at edge N+4 and leaves it unchanged before then. This load ignores the mask and, for the same register and edge, takes priority over a masked transfer.
- R6: While `in_en` is high, a rising edge on `hw_upd` that is first sampled at edge N causes a masked transfer at edge N+2.
- R7: While `in_en` is high, a rising edge on `hw_txen` that is first sampled at edge N causes a masked transfer at edge N+2.
- R8: While `in_en` is low, activity on `hw_upd` and `hw_txen` leaves the slaves unchanged and produces no `upd_done`.
- R9: Holding `sw_txen` high, or taking it low, starts no transfer. Only its low-to-high transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Processor write strobe for a master register |
| wr_addr | input | AW | Index of the master register to write |
| wr_data | input | DW | Value to write |
| mask_we | input | 1 | Write strobe for the update mask |
| mask_d | input | NREG | New update mask, one bit per register |
| imm_mode | input | 1 | Enables the immediate write-through path |
| sw_txen | input | 1 | Software transmit-enable bit; its rising edge is an update event |
| in_en | input | 1 | Accepts the two external pins as event sources |
| hw_txen | input | 1 | External transmit-enable pin, asynchronous |
| hw_upd | input | 1 | External update pin, asynchronous |
| slave_q | output | NREG*DW | All slave registers, concatenated |
| upd_done | output | 1 | One-cycle pulse after a masked transfer |

## Verification
Each result is due a fixed number of edges after its stimulus. A software edge produces new slaves and `upd_done` in the cycle just after the sampling edge. A pin edge produces them two edges later, and an immediate write four edges later. For each stimulus, the driver records the exact cycle in which the result must appear and the value it must have. It also records the cycle before, where the old value must still hold. The monitor compares only at falling edges and only against entries due in that cycle.

// File: rtl/shadow_cfg_ctrl.sv
module shadow_cfg_ctrl #(
  parameter int NREG    = 4,
  parameter int DW      = 16,
  parameter int IMM_DLY = 4,
  localparam int AW     = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 mask_we,
  input  logic [NREG-1:0]      mask_d,
  input  logic                 imm_mode,
  input  logic                 sw_txen,
  input  logic                 in_en,
  input  logic                 hw_txen,
  input  logic                 hw_upd,
  output logic [NREG*DW-1:0]   slave_q,
  output logic                 upd_done
);

  logic [DW-1:0]   mst [NREG];
  logic [DW-1:0]   slv [NREG];
  logic [NREG-1:0] mask_q;
  logic            sw_q;
  logic [2:0]      tx_s, up_s;
  logic [IMM_DLY-1:0] imm_v;
  logic [AW-1:0]   imm_a [IMM_DLY];

  wire tx_rise  = tx_s[1] & ~tx_s[2];
  wire up_rise  = up_s[1] & ~up_s[2];
  wire evt      = (sw_txen & ~sw_q) | (in_en & (tx_rise | up_rise));
  wire imm_fire = imm_v[IMM_DLY-1];
  wire [AW-1:0] imm_addr = imm_a[IMM_DLY-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      sw_q     <= 1'b0;
      tx_s     <= '0;
      up_s     <= '0;
      imm_v    <= '0;
      upd_done <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        mst[i] <= '0;
        slv[i] <= '0;
      end
      for (int k = 0; k < IMM_DLY; k++) imm_a[k] <= '0;
    end else begin
      sw_q     <= sw_txen;
      tx_s     <= {tx_s[1:0], hw_txen};
      up_s     <= {up_s[1:0], hw_upd};
      upd_done <= evt;
      if (mask_we) mask_q <= mask_d;
      if (wr_en) mst[wr_addr] <= wr_data;
      imm_v[0] <= wr_en & imm_mode;
      imm_a[0] <= wr_addr;
      for (int k = 1; k < IMM_DLY; k++) begin
        imm_v[k] <= imm_v[k-1];
        imm_a[k] <= imm_a[k-1];
      end
      for (int i = 0; i < NREG; i++) begin
        if (imm_fire && imm_addr == AW'(i)) slv[i] <= mst[i];
        else if (evt && mask_q[i])          slv[i] <= mst[i];
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign slave_q[g*DW +: DW] = slv[g];
  end

endmodule

module shadow_cfg_ctrl_chk #(
  parameter int NREG = 4,
  parameter int DW   = 16,
  parameter int AW   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sw_txen,
  input logic               in_en,
  input logic               upd_done,
  input logic [NREG*DW-1:0] slave_q,
  input logic [NREG-1:0]    mask_q,
  input logic               imm_fire,
  input logic [AW-1:0]      imm_addr
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (slave_q == '0 && !upd_done && mask_q == '1));

  // R9
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (!sw_txen || $past(sw_txen)) && !in_en) |=> !upd_done);

  // R2
  slave_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && slave_q != $past(slave_q)) |-> (upd_done || $past(imm_fire)));

  for (genvar g = 0; g < NREG; g++) begin : g_mask
    // R3
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && upd_done && !$past(mask_q[g]) &&
       !($past(imm_fire) && $past(imm_addr) == AW'(g)))
      |-> $stable(slave_q[g*DW +: DW]));
  end

endmodule

bind shadow_cfg_ctrl shadow_cfg_ctrl_chk #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_txen(sw_txen), .in_en(in_en),
  .upd_done(upd_done), .slave_q(slave_q), .mask_q(mask_q),
  .imm_fire(imm_fire), .imm_addr(imm_addr)
);

// File: tb/shadow_cfg_ctrl_bench.sv
`timescale 1ns/1ps
module shadow_cfg_ctrl_bench;
  localparam int NREG = 4;
  localparam int DW   = 16;
  localparam int AW   = 2;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, mask_we = 0, imm_mode = 0, sw_txen = 0, in_en = 0;
  logic hw_txen = 0, hw_upd = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NREG-1:0] mask_d = '0;
  logic [NREG*DW-1:0] slave_q;
  logic upd_done;

  shadow_cfg_ctrl u_shadow_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mask_we(mask_we), .mask_d(mask_d), .imm_mode(imm_mode), .sw_txen(sw_txen),
    .in_en(in_en), .hw_txen(hw_txen), .hw_upd(hw_upd),
    .slave_q(slave_q), .upd_done(upd_done));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int cyc; int kind; int idx; logic [DW-1:0] val; string tag;
  } exp_t;
  exp_t sbq[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [DW-1:0] em [NREG];
  logic [DW-1:0] es [NREG];

  task automatic exp_reg(int dly, int idx, logic [DW-1:0] v, string tag);
    exp_t e;
    e.cyc = cyc + 1 + dly; e.kind = 0; e.idx = idx; e.val = v; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic exp_done(int dly, logic v, string tag);
    exp_t e;
    e.cyc = cyc + 1 + dly; e.kind = 1; e.idx = 0; e.val = DW'(v); e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic set_mask(logic [NREG-1:0] m);
    mask_we = 1; mask_d = m;
    tick();
    mask_we = 0;
  endtask

  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].cyc == cyc) begin
        logic [DW-1:0] act;
        act = (sbq[i].kind == 0) ? slave_q[sbq[i].idx*DW +: DW] : DW'(upd_done);
        n_cmp++;
        if (act !== sbq[i].val) begin
          n_bad++;
          $display("FAIL %s: kind %0d idx %0d at cycle %0d actual %h expected %h",
                   sbq[i].tag, sbq[i].kind, sbq[i].idx, cyc, act, sbq[i].val);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin em[i] = '0; es[i] = '0; end
    tick(3);
    rst_n = 1;
    // R1: reset values
    for (int i = 0; i < NREG; i++) exp_reg(0, i, '0, "R1");
    exp_done(0, 0, "R1");
    tick();

    // R2: masters only
    for (int i = 0; i < NREG; i++) begin
      em[i] = DW'(16'h1111 * (i + 1));
      wr(i, em[i]);
    end
    for (int i = 0; i < NREG; i++) exp_reg(0, i, '0, "R2");
    tick();

    // R3/R4: software edge with reset mask (all ones)
    sw_txen = 1;
    for (int i = 0; i < NREG; i++) begin exp_reg(0, i, em[i], "R3"); es[i] = em[i]; end
    exp_done(0, 1, "R4");
    exp_done(1, 0, "R4");
    tick();
    // R9: held high and falling edge
    for (int k = 0; k < 3; k++) begin exp_done(0, 0, "R9"); tick(); end
    sw_txen = 0;
    exp_done(0, 0, "R9");
    exp_done(1, 0, "R9");
    tick(2);

    // R3: partial mask
    set_mask(4'b0101);
    for (int i = 0; i < NREG; i++) begin
      em[i] = DW'(16'hA0A0 + i);
      wr(i, em[i]);
    end
    sw_txen = 1;
    for (int i = 0; i < NREG; i++) begin
      if (i % 2 == 0) es[i] = em[i];
      exp_reg(0, i, es[i], "R3");
    end
    exp_done(0, 1, "R4");
    tick();
    sw_txen = 0;
    tick();

    // R5: immediate path ignores an all-zero mask
    set_mask(4'b0000);
    imm_mode = 1;
    exp_reg(3, 1, es[1], "R5");
    exp_reg(4, 1, 16'h5A5A, "R5");
    exp_reg(4, 3, es[3], "R5");
    exp_done(4, 0, "R5");
    wr(1, 16'h5A5A);
    em[1] = 16'h5A5A; es[1] = 16'h5A5A;
    tick(6);
    imm_mode = 0;

    // R8: pins ignored while disabled
    set_mask(4'b1111);
    em[0] = 16'hBEEF;
    wr(0, em[0]);
    in_en = 0; hw_upd = 1; hw_txen = 1;
    for (int k = 0; k < 6; k++) begin
      exp_reg(0, 0, es[0], "R8");
      exp_done(0, 0, "R8");
      tick();
    end
    hw_upd = 0; hw_txen = 0;
    tick(5);

    // R6: hardware update pin
    in_en = 1;
    hw_upd = 1;
    exp_reg(1, 0, es[0], "R6");
    exp_done(1, 0, "R6");
    for (int i = 0; i < NREG; i++) begin exp_reg(2, i, em[i], "R6"); es[i] = em[i]; end
    exp_done(2, 1, "R6");
    exp_done(3, 0, "R6");
    tick(4);
    hw_upd = 0;
    tick(4);

    // R7: hardware transmit-enable pin
    em[2] = 16'hC3C3;
    wr(2, em[2]);
    hw_txen = 1;
    exp_reg(1, 2, es[2], "R7");
    exp_reg(2, 2, em[2], "R7");
    exp_done(2, 1, "R7");
    es[2] = em[2];
    tick(4);
    hw_txen = 0;
    tick(6);

    if (sbq.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
    end
    summary();
  end
endmodule